// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Sequencer

This block decides, for each of twelve output clock channels, whether the channel's gated copy of the source clock runs and whether its output pair is driven. A channel runs only when software has set its enable bit and its active-low enable pin is pulled low. Enable pins are asynchronous to the source clock. Each pin is synchronized, and any change in the combined decision has to persist for a fixed settle window before it takes effect. Start and stop therefore land a bounded number of output clock cycles after the pin moves, and a short glitch on a pin is ignored. The gate is moved only while the source clock is low, so every pulse that leaves the block is full width.

Device bring-up is controlled by an active-low power-good input. On its first assertion after reset, the block captures the bandwidth and bypass strap pins, holds them, and releases the channels. An asynchronous active-high power-down input stops every channel and undrives every pair at once. It also clears the captured straps, so a fresh power-good assertion is needed afterwards.

Top module: `outclk_seq`

## Requirements
- R1: A channel drives its pair and passes clock only when its register enable bit is 1 and its active-low enable pin is 0. Any other combination settles to off.
- R2: A change on an enable pin first takes effect on the output at the rising source clock edge numbered SETTLE+3, counting the first rising edge after the change as 1. The default SETTLE of 5 gives edge 8, which lies within the permitted 4 to 12 cycles. This applies to both the first pulse after an enable and the first missing pulse after a disable.
- R3: A disabled channel holds its drive enable at 0, so the pair is high impedance, and holds its gated clock low.
- R4: The gated clock of a channel equals the source clock during a whole high phase or stays low for the whole phase. Gate and drive enable change only at falling source clock edges.
- R5: On the first power-good assertion after reset, the bandwidth and bypass strap values are captured and presented on bw_sel and byp_sel. Later changes on the strap pins have no effect until the next reset or power-down.
- R6: Until power-good has been seen, pwr_up stays 0 and every channel stays off, whatever the enable pins and bits say. Once set, pwr_up stays 1 until the next reset or power-down.
- R7: Power-down asserted high turns off every drive enable and gated clock immediately, without waiting for a clock edge. It clears pwr_up and the captured straps. After power-down is released, channels stay off until power-good is asserted again.
- R8: If an enable pin change reverts before the settle window ends, the channel keeps its previous state.
- R9: Channels are independent. A change on one channel's pin or bit does not alter any other channel's output.
- R10: While reset is asserted, all drive enables, gated clocks, pwr_up, bw_sel and byp_sel are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock that the gated outputs copy |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwrgd_n | input | 1 | Active-low power-good; its first assertion captures straps and releases channels |
| pd | input | 1 | Asynchronous active-high power-down |
| strap_bw | input | 1 | Bandwidth strap pin, captured at power-good |
| strap_byp | input | 1 | Bypass strap pin, captured at power-good |
| oe_n | input | 12 | Active-low per-channel enable pins, asynchronous |
| reg_en | input | 12 | Per-channel register enable bits, in the clk_src domain |
| clk_out | output | 12 | Gated clock per channel |
| drv_en | output | 12 | Per-channel output drive enable; 0 means high impedance |
| pwr_up | output | 1 | Set once power-good has released the channels |
| bw_sel | output | 1 | Captured bandwidth strap |
| byp_sel | output | 1 | Captured bypass strap |

## Verification
The assertions rely on three properties of the inputs. The register enable bits change synchronously to clk_src. Reset and power-down are the only paths that bring pwr_up back down. SETTLE is small enough that the settle counter never runs past its terminal count. The stimulus meets these by driving every input two time units after a rising edge, including the enable bits, and by moving pins, straps and power-good only at those instants. Power-down and reset are the only asynchronous events, and the bench's reference model clears its own state at the moment it sees either.

// File: rtl/outclk_seq_pkg.sv
package outclk_seq_pkg;
  parameter int unsigned CH_COUNT_DEF = 12;
  parameter int unsigned SETTLE_DEF   = 5;

  typedef struct packed {
    logic bw;
    logic byp;
  } strap_t;
endpackage

// File: rtl/outclk_rst_sync.sv
module outclk_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign srst_n = out_q;
endmodule

// File: rtl/outclk_bit_sync.sv
module outclk_bit_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      sync_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/outclk_strap_cap.sv
module outclk_strap_cap
  import outclk_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pg_n_s,
  input  strap_t straps_s,
  output logic   run,
  output strap_t straps_q
);
  logic   run_q, run_d;
  strap_t hold_q, hold_d;
  logic   cap_en;

  always_comb begin
    cap_en = !run_q && !pg_n_s;
    run_d  = run_q;
    hold_d = hold_q;
    if (cap_en) begin
      run_d  = 1'b1;
      hold_d = straps_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hold_q <= '0;
    end else if (cap_en) begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  assign run      = run_q;
  assign straps_q = hold_q;

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(hold_q)); // R5
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q); // R6
endmodule

// File: rtl/outclk_chan.sv
module outclk_chan #(
  parameter int unsigned SETTLE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic en_bit,
  input  logic oe_n_s,
  output logic gate,
  output logic clk_gated
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

  logic          want;
  logic          cur_q, cur_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          gate_q;

  always_comb begin
    want  = run && en_bit && !oe_n_s;
    cur_d = cur_q;
    cnt_d = '0;
    if (want != cur_q) begin
      if (cnt_q == CNT_LAST) begin
        cur_d = want;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= cur_q;
    end
  end

  assign gate      = gate_q;
  assign clk_gated = clk & gate_q;

  AST_SWITCH_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != CNT_LAST) |=> $stable(cur_q)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R2
  AST_OFF_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !cur_q); // R6
  AST_ON_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_q) |-> $past(en_bit && !oe_n_s)); // R1
endmodule

// File: rtl/outclk_seq.sv
module outclk_seq
  import outclk_seq_pkg::*;
#(
  parameter int unsigned NCH    = CH_COUNT_DEF,
  parameter int unsigned SETTLE = SETTLE_DEF
) (
  input  logic           clk_src,
  input  logic           rst_n,
  input  logic           pwrgd_n,
  input  logic           pd,
  input  logic           strap_bw,
  input  logic           strap_byp,
  input  logic [NCH-1:0] oe_n,
  input  logic [NCH-1:0] reg_en,
  output logic [NCH-1:0] clk_out,
  output logic [NCH-1:0] drv_en,
  output logic           pwr_up,
  output logic           bw_sel,
  output logic           byp_sel
);
  localparam int unsigned HI_W = NCH + 1;

  logic          arst_n;
  logic          core_rst_n;
  logic [NCH:0]  hi_sync;
  logic [NCH-1:0] oe_n_s;
  logic          pg_n_s;
  strap_t        straps_raw, straps_s, straps_q;
  logic          run;

  assign arst_n = rst_n && !pd;

  outclk_rst_sync u_rst (
    .clk    (clk_src),
    .arst_n (arst_n),
    .srst_n (core_rst_n)
  );

  outclk_bit_sync #(.WIDTH(HI_W), .RST_VAL(1'b1)) u_hi_sync (
    .clk   (clk_src),
    .rst_n (core_rst_n),
    .d     ({pwrgd_n, oe_n}),
    .q     (hi_sync)
  );

  assign oe_n_s = hi_sync[NCH-1:0];
  assign pg_n_s = hi_sync[NCH];

  assign straps_raw.bw  = strap_bw;
  assign straps_raw.byp = strap_byp;

  outclk_bit_sync #(.WIDTH(2), .RST_VAL(1'b0)) u_strap_sync (
    .clk   (clk_src),
    .rst_n (core_rst_n),
    .d     (straps_raw),
    .q     (straps_s)
  );

  outclk_strap_cap u_cap (
    .clk      (clk_src),
    .rst_n    (core_rst_n),
    .pg_n_s   (pg_n_s),
    .straps_s (straps_s),
    .run      (run),
    .straps_q (straps_q)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    outclk_chan #(.SETTLE(SETTLE)) u_chan (
      .clk       (clk_src),
      .rst_n     (core_rst_n),
      .run       (run),
      .en_bit    (reg_en[ch]),
      .oe_n_s    (oe_n_s[ch]),
      .gate      (drv_en[ch]),
      .clk_gated (clk_out[ch])
    );
  end

  assign pwr_up  = run;
  assign bw_sel  = straps_q.bw;
  assign byp_sel = straps_q.byp;

  AST_PD_QUIET: assert property (@(posedge clk_src)
    pd |-> (drv_en == '0) && !pwr_up); // R7
endmodule

// File: tb/outclk_seq_test.sv
module outclk_seq_test;
  localparam int NCH    = 12;
  localparam int SETTLE = 5;
  localparam int PERIOD = 10;

  logic clk, rst_n, pwrgd_n, pd, strap_bw, strap_byp;
  logic [NCH-1:0] oe_n, reg_en;
  logic [NCH-1:0] clk_out, drv_en;
  logic pwr_up, bw_sel, byp_sel;

  int n_chk, n_fail;
  bit done;

  outclk_seq #(.NCH(NCH), .SETTLE(SETTLE)) uut (
    .clk_src(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .pd(pd),
    .strap_bw(strap_bw), .strap_byp(strap_byp), .oe_n(oe_n), .reg_en(reg_en),
    .clk_out(clk_out), .drv_en(drv_en), .pwr_up(pwr_up),
    .bw_sel(bw_sel), .byp_sel(byp_sel)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  // behavioural reference model
  int             m_cnt [NCH];
  logic [NCH-1:0] m_cur, m_oe1, m_oe2, exp_gate;
  logic m_pg1, m_pg2, m_sb1, m_sb2, m_sy1, m_sy2, m_run, m_bw, m_by;
  int   m_rdly;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
    m_cur = '0; m_oe1 = '1; m_oe2 = '1; exp_gate = '0;
    m_pg1 = 1; m_pg2 = 1; m_sb1 = 0; m_sb2 = 0; m_sy1 = 0; m_sy2 = 0;
    m_run = 0; m_bw = 0; m_by = 0; m_rdly = 0;
  endtask

  task automatic m_edge();
    if (!rst_n || pd) begin
      m_reset();
    end else if (m_rdly < 2) begin
      m_rdly++;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit want;
        want = m_run && reg_en[i] && !m_oe2[i];
        if (want != m_cur[i]) begin
          if (m_cnt[i] == SETTLE - 1) begin
            m_cur[i] = want;
            m_cnt[i] = 0;
          end else begin
            m_cnt[i]++;
          end
        end else begin
          m_cnt[i] = 0;
        end
      end
      if (!m_run && !m_pg2) begin
        m_run = 1; m_bw = m_sb2; m_by = m_sy2;
      end
      m_oe2 = m_oe1; m_oe1 = oe_n;
      m_pg2 = m_pg1; m_pg1 = pwrgd_n;
      m_sb2 = m_sb1; m_sb1 = strap_bw;
      m_sy2 = m_sy1; m_sy1 = strap_byp;
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    m_edge();
    #3;
    if (!rst_n || pd) m_reset();
    check("R4 clk_out high phase", 32'(clk_out), 32'(exp_gate));
    #2;
    exp_gate = m_cur;
    #2;
    check("R1 drv_en", 32'(drv_en), 32'(exp_gate));
    check("R3 clk_out low phase", 32'(clk_out), 32'(0));
    check("R6 pwr_up", 32'(pwr_up), 32'(m_run));
    check("R5 bw_sel", 32'(bw_sel), 32'(m_bw));
    check("R5 byp_sel", 32'(byp_sel), 32'(m_by));
  end

  task automatic drive_slot();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    int k;
    n_chk = 0; n_fail = 0; done = 0;
    m_reset();
    rst_n = 0; pd = 0; pwrgd_n = 1; strap_bw = 0; strap_byp = 0;
    oe_n = '1; reg_en = '1;
    wait_cyc(3);
    check("R10 reset drv_en", 32'(drv_en), 32'(0));
    check("R10 reset pwr_up", 32'(pwr_up), 32'(0));
    check("R10 reset straps", 32'({bw_sel, byp_sel}), 32'(0));
    rst_n = 1;

    // R6: pins and bits enabled, no power-good yet
    oe_n[3:0] = 4'b0000;
    wait_cyc(20);
    check("R6 no power-good drv_en", 32'(drv_en), 32'(0));
    check("R6 no power-good pwr_up", 32'(pwr_up), 32'(0));

    // R5: straps captured at power-good, later changes ignored
    strap_bw = 1; strap_byp = 0;
    drive_slot();
    pwrgd_n = 0;
    wait_cyc(6);
    check("R5 bw captured", 32'(bw_sel), 32'(1));
    check("R5 byp captured", 32'(byp_sel), 32'(0));
    strap_bw = 0; strap_byp = 1;
    wait_cyc(8);
    check("R5 bw held", 32'(bw_sel), 32'(1));
    check("R5 byp held", 32'(byp_sel), 32'(0));
    wait_cyc(6);
    check("R6 channels up after power-good", 32'(drv_en[3:0]), 32'(4'hF));

    // R1: pin low but bit clear; bit set but pin high
    reg_en[2] = 0;
    oe_n[6] = 1;
    wait_cyc(16);
    check("R1 bit clear keeps off", 32'(drv_en[2]), 32'(0));
    check("R1 pin high keeps off", 32'(drv_en[6]), 32'(0));
    check("R1 both agree on", 32'(drv_en[0]), 32'(1));
    @(posedge clk); #3;
    check("R3 disabled clk_out low in high phase", 32'(clk_out[2]), 32'(0));
    check("R4 enabled clk_out full high phase", 32'(clk_out[0]), 32'(1));

    // R2: start latency on channel 7
    drive_slot();
    oe_n[7] = 0;
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk); #3;
      if (clk_out[7] && k == 0) k = i;
    end
    check("R2 start edge", 32'(k), 32'(SETTLE + 3));
    check("R9 neighbour unchanged", 32'({drv_en[8], drv_en[6], drv_en[0]}), 32'(3'b001));

    // R2: stop latency on channel 7
    drive_slot();
    oe_n[7] = 1;
    k = 0;
    for (int i = 1; i <= 20; i++) begin
      @(posedge clk); #3;
      if (!clk_out[7] && k == 0) k = i;
    end
    check("R2 stop edge", 32'(k), 32'(SETTLE + 3));

    // R8: short pulses are filtered in both directions
    drive_slot();
    oe_n[8] = 0;
    oe_n[0] = 1;
    wait_cyc(3);
    oe_n[8] = 1;
    oe_n[0] = 0;
    wait_cyc(15);
    check("R8 short enable filtered", 32'(drv_en[8]), 32'(0));
    check("R8 short disable filtered", 32'(drv_en[0]), 32'(1));

    // R7: asynchronous power-down
    drive_slot();
    pd = 1;
    #1;
    check("R7 pd drv_en immediate", 32'(drv_en), 32'(0));
    check("R7 pd clk_out immediate", 32'(clk_out), 32'(0));
    check("R7 pd pwr_up cleared", 32'(pwr_up), 32'(0));
    pwrgd_n = 1;
    wait_cyc(3);
    pd = 0;
    wait_cyc(15);
    check("R7 stays off without power-good", 32'(drv_en), 32'(0));
    check("R7 straps cleared", 32'({bw_sel, byp_sel}), 32'(0));
    pwrgd_n = 0;
    wait_cyc(16);
    check("R7 up again after power-good", 32'(pwr_up), 32'(1));
    check("R7 channel 0 back on", 32'(drv_en[0]), 32'(1));
    check("R5 straps recaptured", 32'({bw_sel, byp_sel}), 32'(2'b01));

    wait_cyc(2);
    done = 1;
    summary();
  end
endmodule